// File: doc/BRIEF.md
# I2C Byte Master with Repeated Start

This block is the bus side of an I2C master. Software supplies a 7-bit target address, a direction bit and, one at a time, the data bytes to send. A one-cycle go pulse makes the engine issue a start condition, shift out the address byte with the direction bit appended, and then send each byte from its one-byte holding register. After each acknowledge, the engine does one of three things. If the holding register is empty, it closes the transfer with a stop. If a byte is waiting, it sends that byte. If a restart has been requested, it issues a repeated start and sends the stored address again.

Both bus lines are open-drain. The block outputs pull-low enables for SCL and SDA and reads SDA back. Each SCL bit is built from four quarter-periods whose length is a parameter. A missing acknowledge aborts the transfer with a stop. Lost arbitration aborts it at once, releasing both lines without a stop. Either case raises a failure flag that stays set until software clears it. A separate NACK flag records every acknowledge bit that was sampled high.

Top module: `i2c_rs_master`

## Requirements
- R1: After reset, both pull-low enables (scl_oe, sda_oe) are 0. The outputs busy, restart_pending, fail and nack_seen are 0, and tx_empty is 1.
- R2: The first byte after every start is {dev_addr[6:0], dir_read}, sent MSB first, so the direction bit is the last of the eight. dir_read = 1 means read and 0 means write. Inside a bit, SDA changes only while SCL is low.
- R3: A go pulse, accepted while master_en = 1, produces a start (SDA falls while SCL is high). After each acknowledged byte, the byte in the holding register is sent if tx_load has filled it; otherwise a stop follows (SDA rises while SCL is high). Loading sets tx_empty to 0, and the byte being taken for sending sets it back to 1.
- R4: A restart request (restart_set while master_en = 1) sets restart_pending. After the current acknowledge bit, the engine issues a start and resends the address byte from the current dev_addr and dir_read. restart_pending clears once that start has been generated.
- R5: While master_en = 0, restart_set and go have no effect. restart_pending stays 0, and no start appears on the bus.
- R6: An acknowledge bit sampled high sets nack_seen and fail, clears restart_pending, and ends the transfer with a stop.
- R7: If SDA is sampled low during a data or address bit in which the engine released it, arbitration is lost. fail is set, both lines are released in the next cycle, and the engine goes idle without a stop.
- R8: fail stays set until a fail_clr pulse, and nack_seen stays set until a nack_clr pulse. Later successful transfers do not clear either flag.
- R9: During a byte's bits, SCL is high for 2*QTR_CYCLES clock cycles per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master mode enable; go and restart requests are honoured only when 1 |
| go | input | 1 | One-cycle pulse that starts a transfer from idle |
| dev_addr | input | 7 | Target address |
| dir_read | input | 1 | Direction bit sent as address bit 0: 1 read, 0 write |
| restart_set | input | 1 | Pulse requesting a repeated start after the current acknowledge |
| tx_load | input | 1 | Pulse writing tx_data into the holding register |
| tx_data | input | 8 | Byte to be sent |
| fail_clr | input | 1 | Pulse clearing the failure flag |
| nack_clr | input | 1 | Pulse clearing the NACK flag |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Engine is running a transfer |
| restart_pending | output | 1 | A restart request is waiting to be issued |
| fail | output | 1 | Sticky failure flag (NACK or lost arbitration) |
| nack_seen | output | 1 | Sticky flag: an acknowledge bit was sampled high |
| tx_empty | output | 1 | Holding register can take a byte |

## Verification
The two hardest states to reach from the ports are a restart request that is pending exactly when an acknowledge completes, and a lost arbitration in the middle of an address bit. To reach the first, the bench waits for tx_empty to rise, which marks the address acknowledge, and raises the restart request during the following data byte. It also changes dir_read, so the resent address shows that the current register contents were used. For lost arbitration, a second bus driver pulls SDA low as soon as the bench's bus monitor sees the start. The address MSB is 1, so the engine releases SDA in the first bit and must detect the conflict. The bench checks that no stop is seen before it lets go of the line.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BIT   = 2'd2,
        ST_STOP  = 2'd3
    } eng_state_t;

    // Engine state: phase within a bit, bit index (8 = acknowledge), shifter
    typedef struct packed {
        eng_state_t st;
        logic [1:0] qtr;
        logic [3:0] bitn;
        logic [7:0] shreg;
        logic       scl_low;
        logic       sda_low;
    } eng_t;

    // Software-visible flags and the transmit holding byte
    typedef struct packed {
        logic       restart;
        logic       fail;
        logic       nack;
        logic       full;
        logic [7:0] hold;
    } flags_t;

endpackage

// File: rtl/i2c_rs_tick.sv
module i2c_rs_tick #(
    parameter int QTR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_rs_flags.sv
module i2c_rs_flags
    import i2c_rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic       restart_set,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    input  logic       fail_clr,
    input  logic       nack_clr,
    input  logic       ev_start_done,
    input  logic       ev_nack,
    input  logic       ev_arb,
    input  logic       ev_consume,
    output logic       restart_o,
    output logic       fail_o,
    output logic       nack_o,
    output logic       full_o,
    output logic [7:0] hold_o
);
    flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (fail_clr)           f_d.fail = 1'b0;
        if (ev_nack || ev_arb)  f_d.fail = 1'b1;
        if (nack_clr)           f_d.nack = 1'b0;
        if (ev_nack)            f_d.nack = 1'b1;
        if (restart_set && master_en)              f_d.restart = 1'b1;
        if (ev_start_done || ev_nack || !master_en) f_d.restart = 1'b0;
        if (ev_consume)         f_d.full = 1'b0;
        if (tx_load) begin
            f_d.full = 1'b1;
            f_d.hold = tx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign restart_o = f_q.restart;
    assign fail_o    = f_q.fail;
    assign nack_o    = f_q.nack;
    assign full_o    = f_q.full;
    assign hold_o    = f_q.hold;

    assert_restart_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !f_q.restart);

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.fail && !fail_clr) |=> f_q.fail);

    assert_nack_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.nack && !nack_clr) |=> f_q.nack);
endmodule

// File: rtl/i2c_rs_master.sv
module i2c_rs_master
    import i2c_rs_pkg::*;
#(
    parameter int QTR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic       go,
    input  logic [6:0] dev_addr,
    input  logic       dir_read,
    input  logic       restart_set,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    input  logic       fail_clr,
    input  logic       nack_clr,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       restart_pending,
    output logic       fail,
    output logic       nack_seen,
    output logic       tx_empty
);
    localparam logic [3:0] ACK_BIT = 4'd8;

    eng_t e_d, e_q;
    logic tick;
    logic ev_start_done, ev_nack, ev_arb, ev_consume;
    logic restart_q, full_q;
    logic [7:0] hold_q;

    i2c_rs_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (e_q.st != ST_IDLE),
        .tick (tick)
    );

    i2c_rs_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_en    (master_en),
        .restart_set  (restart_set),
        .tx_load      (tx_load),
        .tx_data      (tx_data),
        .fail_clr     (fail_clr),
        .nack_clr     (nack_clr),
        .ev_start_done(ev_start_done),
        .ev_nack      (ev_nack),
        .ev_arb       (ev_arb),
        .ev_consume   (ev_consume),
        .restart_o    (restart_q),
        .fail_o       (fail),
        .nack_o       (nack_seen),
        .full_o       (full_q),
        .hold_o       (hold_q)
    );

    always_comb begin
        e_d           = e_q;
        ev_start_done = 1'b0;
        ev_nack       = 1'b0;
        ev_arb        = 1'b0;
        ev_consume    = 1'b0;
        unique case (e_q.st)
            ST_IDLE: begin
                if (go && master_en) begin
                    e_d.st  = ST_START;
                    e_d.qtr = 2'd0;
                end
            end
            ST_START: begin
                if (tick) begin
                    e_d.qtr = e_q.qtr + 2'd1;
                    unique case (e_q.qtr)
                        2'd0: e_d.sda_low = 1'b0;
                        2'd1: e_d.scl_low = 1'b0;
                        2'd2: e_d.sda_low = 1'b1;
                        default: begin
                            e_d.st        = ST_BIT;
                            e_d.qtr       = 2'd0;
                            e_d.bitn      = 4'd0;
                            e_d.shreg     = {dev_addr, dir_read};
                            e_d.scl_low   = 1'b1;
                            ev_start_done = 1'b1;
                        end
                    endcase
                end
            end
            ST_BIT: begin
                if (tick) begin
                    e_d.qtr = e_q.qtr + 2'd1;
                    unique case (e_q.qtr)
                        2'd0: e_d.sda_low = (e_q.bitn != ACK_BIT) && !e_q.shreg[7];
                        2'd1: e_d.scl_low = 1'b0;
                        2'd2: ;
                        default: begin
                            e_d.qtr     = 2'd0;
                            e_d.scl_low = 1'b1;
                            if (e_q.bitn != ACK_BIT) begin
                                if (!e_q.sda_low && !sda_i) begin
                                    ev_arb      = 1'b1;
                                    e_d.st      = ST_IDLE;
                                    e_d.scl_low = 1'b0;
                                    e_d.sda_low = 1'b0;
                                end else begin
                                    e_d.shreg = {e_q.shreg[6:0], 1'b0};
                                    e_d.bitn  = e_q.bitn + 4'd1;
                                end
                            end else if (sda_i) begin
                                ev_nack = 1'b1;
                                e_d.st  = ST_STOP;
                            end else if (restart_q && master_en) begin
                                e_d.st = ST_START;
                            end else if (full_q) begin
                                ev_consume = 1'b1;
                                e_d.bitn   = 4'd0;
                                e_d.shreg  = hold_q;
                            end else begin
                                e_d.st = ST_STOP;
                            end
                        end
                    endcase
                end
            end
            default: begin
                if (tick) begin
                    e_d.qtr = e_q.qtr + 2'd1;
                    unique case (e_q.qtr)
                        2'd0: e_d.sda_low = 1'b1;
                        2'd1: e_d.scl_low = 1'b0;
                        2'd2: e_d.sda_low = 1'b0;
                        default: begin
                            e_d.st  = ST_IDLE;
                            e_d.qtr = 2'd0;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: ST_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign scl_oe          = e_q.scl_low;
    assign sda_oe          = e_q.sda_low;
    assign busy            = (e_q.st != ST_IDLE);
    assign restart_pending = restart_q;
    assign tx_empty        = !full_q;

    assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_BIT && !$stable(e_q.sda_low)) |-> e_q.scl_low);

    assert_restart_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start_done |=> !restart_q);

    assert_nack_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> (nack_seen && fail && !restart_q && e_q.st == ST_STOP));

    assert_arb_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb |=> (!scl_oe && !sda_oe && !busy && fail));

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_IDLE) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_i2c_rs_master.sv
module tb_i2c_rs_master;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b0, go = 1'b0, dir_read = 1'b0, restart_set = 1'b0;
    logic tx_load = 1'b0, fail_clr = 1'b0, nack_clr = 1'b0;
    logic [6:0] dev_addr = 7'h00;
    logic [7:0] tx_data = 8'h00;
    logic scl_oe, sda_oe, busy, restart_pending, fail, nack_seen, tx_empty;
    logic slave_pull = 1'b0, arb_pull = 1'b0;
    wire  sda_bus = ~(sda_oe | slave_pull | arb_pull);

    int checks = 0, errors = 0;
    int nstart = 0, nstop = 0, nbytes = 0, start_byte = 0, ack_hi = 0;
    int nack_idx = -1;
    logic [7:0] log_b [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_rs_master #(.QTR_CYCLES(QTR)) dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .go(go),
        .dev_addr(dev_addr), .dir_read(dir_read), .restart_set(restart_set),
        .tx_load(tx_load), .tx_data(tx_data), .fail_clr(fail_clr),
        .nack_clr(nack_clr), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .restart_pending(restart_pending), .fail(fail),
        .nack_seen(nack_seen), .tx_empty(tx_empty)
    );

    // Bus monitor and acknowledging target
    int cyc = 0, rise_cyc = 0, bitn = 0;
    logic ack_phase = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] sh = 8'h00;
    always @(negedge clk) begin
        logic sc, sd;
        cyc++;
        sc = ~scl_oe;
        sd = sda_bus;
        if (sc && p_scl && p_sda && !sd) begin
            nstart++; start_byte = nbytes; bitn = 0; ack_phase = 1'b0;
        end else if (sc && p_scl && !p_sda && sd) begin
            nstop++;
        end else if (sc && !p_scl) begin
            rise_cyc = cyc;
            if (!ack_phase && bitn < 8) begin sh = {sh[6:0], sd}; bitn++; end
        end else if (!sc && p_scl) begin
            if (ack_phase) begin
                ack_hi = cyc - rise_cyc;
                slave_pull <= 1'b0; ack_phase = 1'b0; bitn = 0;
            end else if (bitn == 8) begin
                log_b[nbytes % 64] = sh;
                slave_pull <= (nbytes != nack_idx);
                nbytes++; ack_phase = 1'b1;
            end
        end
        p_scl = sc; p_sda = sd;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_go();
        @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
    endtask
    task automatic pulse_restart();
        @(negedge clk); restart_set = 1'b1; @(negedge clk); restart_set = 1'b0;
    endtask
    task automatic load(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    endtask
    task automatic clear_flags();
        @(negedge clk); fail_clr = 1'b1; nack_clr = 1'b1;
        @(negedge clk); fail_clr = 1'b0; nack_clr = 1'b0;
    endtask
    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
    endtask
    task automatic wait_tx_empty();
        int n = 0;
        while (!tx_empty && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0); chk("R1 restart", restart_pending, 0);
        chk("R1 fail", fail, 0); chk("R1 nack", nack_seen, 0);
        chk("R1 tx_empty", tx_empty, 1);
    endtask

    task automatic t_write();
        int b0 = nbytes, s0 = nstart, p0 = nstop;
        nack_idx = -1; dev_addr = 7'h50; dir_read = 1'b0;
        load(8'hA5);
        chk("R3 tx_empty after load", tx_empty, 0);
        pulse_go();
        wait_tx_empty();
        load(8'h3C);
        wait_idle();
        chk("R3 byte count", nbytes - b0, 3);
        chk("R2 write address byte", log_b[b0 % 64], 8'hA0);
        chk("R3 data byte 1", log_b[(b0+1) % 64], 8'hA5);
        chk("R3 data byte 2", log_b[(b0+2) % 64], 8'h3C);
        chk("R3 starts", nstart - s0, 1);
        chk("R3 stops", nstop - p0, 1);
        chk("R3 fail clear", fail, 0);
        chk("R9 SCL high width", ack_hi, 2*QTR);
        chk("R3 bus released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_read_dir();
        int b0 = nbytes, p0 = nstop;
        dev_addr = 7'h2B; dir_read = 1'b1;
        pulse_go(); wait_idle();
        chk("R2 read address byte", log_b[b0 % 64], 8'h57);
        chk("R3 stop when holding empty", nstop - p0, 1);
        chk("R3 single byte", nbytes - b0, 1);
    endtask

    task automatic t_restart();
        int b0 = nbytes, s0 = nstart, p0 = nstop;
        dev_addr = 7'h50; dir_read = 1'b0;
        load(8'h11);
        pulse_go();
        wait_tx_empty();
        pulse_restart();
        chk("R4 restart pending", restart_pending, 1);
        dir_read = 1'b1;
        wait_idle();
        chk("R4 byte count", nbytes - b0, 3);
        chk("R4 data before restart", log_b[(b0+1) % 64], 8'h11);
        chk("R4 resent address", log_b[(b0+2) % 64], 8'hA1);
        chk("R4 starts", nstart - s0, 2);
        chk("R4 restart position", start_byte - b0, 2);
        chk("R4 stops", nstop - p0, 1);
        chk("R4 restart cleared", restart_pending, 0);
    endtask

    task automatic t_not_master();
        int s0 = nstart;
        master_en = 1'b0;
        pulse_restart();
        pulse_go();
        repeat (60) @(negedge clk);
        chk("R5 restart ignored", restart_pending, 0);
        chk("R5 go ignored busy", busy, 0);
        chk("R5 no start", nstart - s0, 0);
        master_en = 1'b1;
    endtask

    task automatic t_nack_addr();
        int b0 = nbytes, s0 = nstart, p0 = nstop;
        nack_idx = b0; dev_addr = 7'h50; dir_read = 1'b0;
        pulse_go();
        repeat (20) @(negedge clk);
        pulse_restart();
        wait_idle();
        chk("R6 fail", fail, 1); chk("R6 nack", nack_seen, 1);
        chk("R6 restart cleared", restart_pending, 0);
        chk("R6 stop", nstop - p0, 1); chk("R6 no restart", nstart - s0, 1);
        nack_idx = -1;
    endtask

    task automatic t_sticky();
        dev_addr = 7'h33; dir_read = 1'b0;
        pulse_go(); wait_idle();
        chk("R8 fail sticky", fail, 1);
        chk("R8 nack sticky", nack_seen, 1);
        @(negedge clk); fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;
        chk("R8 fail cleared", fail, 0);
        chk("R8 nack kept", nack_seen, 1);
        @(negedge clk); nack_clr = 1'b1; @(negedge clk); nack_clr = 1'b0;
        chk("R8 nack cleared", nack_seen, 0);
    endtask

    task automatic t_nack_data();
        int b0 = nbytes, p0 = nstop;
        nack_idx = b0 + 1; dev_addr = 7'h41; dir_read = 1'b0;
        load(8'h77); load(8'h77);
        pulse_go(); wait_idle();
        chk("R6 data nack fail", fail, 1);
        chk("R6 data nack flag", nack_seen, 1);
        chk("R6 data nack stop", nstop - p0, 1);
        chk("R6 data nack bytes", nbytes - b0, 2);
        nack_idx = -1;
        clear_flags();
    endtask

    task automatic t_arb();
        int s0 = nstart, p0 = nstop, n = 0;
        dev_addr = 7'h50; dir_read = 1'b0;
        pulse_go();
        while (nstart == s0 && n < 20000) begin @(negedge clk); n++; end
        arb_pull = 1'b1;
        wait_idle();
        chk("R7 fail", fail, 1);
        chk("R7 no nack", nack_seen, 0);
        chk("R7 lines released", {scl_oe, sda_oe}, 0);
        chk("R7 idle", busy, 0);
        chk("R7 no stop", nstop - p0, 0);
        arb_pull = 1'b0;
        repeat (4) @(negedge clk);
        clear_flags();
    endtask

    logic finished = 1'b0;
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        master_en = 1'b1;
        t_write();
        t_read_dir();
        t_restart();
        t_not_master();
        t_nack_addr();
        t_sticky();
        t_nack_data();
        t_arb();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end
endmodule